// File: doc/BRIEF.md
# Privileged Trap Entry and Return Sequencer

This block decides where execution goes when the core takes a fault, trap or interrupt, and when a privileged return instruction runs. It holds two registers: a vector base register and a saved restart-address register. When a fault is taken, it forms the handler address from the base register plus a per-fault offset. It records where execution should resume, and it asks the register file to switch to the shadow bank if the fault came from ordinary mode. When a return is taken, it jumps back to the saved address and may release the shadow bank.

Bit 0 of any program counter marks privileged mode. A return issued outside privileged mode is not carried out; the block flags an illegal-instruction condition instead. Arithmetic trap requests are not supported: the block flags them and changes no state. Every result appears on the registered outputs one clock after the strobe. `redirect` marks the cycles in which the new `next_pc` and `next_npc` are to be followed.

Top module: `trap_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `next_pc` = BASE_RESET + 0x1, `next_npc` = BASE_RESET + 0x5, `exc_addr` = 0, and `redirect`, `shadow_enter`, `shadow_exit`, `ret_illegal` and `arith_reject` all low.
- R2: A cycle with `fault_take` high and an accepted code gives `redirect` high in the next cycle, with `next_pc` = base + offset. The codes and offsets are: 1 reset 0x0001, 2 machine check 0x0401, 4 interrupt 0x0101, 5 native data-TLB miss 0x0201, 6 privileged data-TLB miss 0x0281, 7 alignment 0x0301, 8 data fault 0x0381, 9 data access violation 0x0381, 10 instruction-TLB miss 0x0181, 11 instruction fault 0x0181, 12 instruction access violation 0x0081, 13 unimplemented opcode 0x0481, 14 FP-disabled 0x0581, 15 privileged call 0x2001, 16 integer overflow 0x0501.
- R3: Whenever `redirect` is high, `next_npc` equals `next_pc` + 4.
- R4: On an accepted fault, `exc_addr` becomes `cur_pc`, with two exceptions. For code 15 it becomes `cur_pc` + 4. For code 4 while `cur_pc[0]` is 1, it keeps its value.
- R5: An accepted fault raises `shadow_enter` for one cycle when `cur_pc[0]` is 0. When `cur_pc[0]` is 1, `shadow_enter` stays low.
- R6: A return (`ret_take` high, `fault_take` low) with `cur_pc[0]` = 1 gives `redirect` high and `next_pc` = `exc_addr` in the next cycle. In that same cycle `shadow_exit` is high exactly when bit 0 of the saved address was 0.
- R7: A return with `cur_pc[0]` = 0 raises `ret_illegal` for one cycle. It gives no `redirect` and leaves `next_pc` and `exc_addr` unchanged.
- R8: `fault_take` with code 3 (arithmetic) raises `arith_reject` for one cycle. It gives no `redirect` and leaves `exc_addr` unchanged.
- R9: When `fault_take` and `ret_take` are high in the same cycle, the fault is handled and the return is dropped: no `shadow_exit`, no `ret_illegal`.
- R10: `fault_take` with code 0 or a code above 16 has no effect: no pulse, and `next_pc` and `exc_addr` keep their values.
- R11: `base_wr` loads `base_wdata` into the base register at the clock edge. A fault taken in that same cycle still uses the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_pc | input | AW | PC of the instruction being trapped or returning; bit 0 = privileged |
| fault_take | input | 1 | Take the fault given by `fault_code` this cycle |
| fault_code | input | 5 | Fault kind, encoded as in R2 (3 = arithmetic) |
| ret_take | input | 1 | Privileged return executes this cycle |
| base_wr | input | 1 | Load the vector base register |
| base_wdata | input | AW | New vector base value |
| next_pc | output | AW | Redirect target |
| next_npc | output | AW | Redirect target + 4 |
| redirect | output | 1 | Follow `next_pc`/`next_npc` this cycle |
| shadow_enter | output | 1 | Request switch to the shadow register bank |
| shadow_exit | output | 1 | Request release of the shadow bank |
| ret_illegal | output | 1 | Return attempted outside privileged mode |
| arith_reject | output | 1 | Unsupported arithmetic trap was requested |
| exc_addr | output | AW | Saved restart address |

## Verification
The hardest case to reach is an interrupt taken while already in privileged mode. The saved address must survive that interrupt. To show it, the stimulus first takes a privileged-call trap from ordinary mode, which stores a known address offset by four. It then raises an interrupt with a PC whose bit 0 is set, and confirms through a later return that the original address was kept. The same chain is used with a fault taken from a privileged PC, so that the saved address has bit 0 set. The following return must then leave the shadow bank in place.

// File: rtl/trap_pkg.sv
// Package: fault encodings, save-address policy and vector offsets shared
// by the trap sequencer. Assumes a 5-bit fault code.
package trap_pkg;

    localparam int CODE_W = 5;
    localparam int OFS_W  = 16;

    typedef enum logic [CODE_W-1:0] {
        FC_NONE    = 5'd0,
        FC_RESET   = 5'd1,
        FC_MCHK    = 5'd2,
        FC_ARITH   = 5'd3,
        FC_INTR    = 5'd4,
        FC_NDTBM   = 5'd5,
        FC_PDTBM   = 5'd6,
        FC_ALIGN   = 5'd7,
        FC_DFAULT  = 5'd8,
        FC_DACV    = 5'd9,
        FC_ITBM    = 5'd10,
        FC_IFAULT  = 5'd11,
        FC_IACV    = 5'd12,
        FC_UNIMP   = 5'd13,
        FC_FPDIS   = 5'd14,
        FC_PCALL   = 5'd15,
        FC_IOVF    = 5'd16
    } fault_e;

    typedef enum logic [1:0] {
        SAVE_KEEP = 2'd0,
        SAVE_PC   = 2'd1,
        SAVE_PC4  = 2'd2
    } save_e;

    // Handler offset for a fault code; unknown codes give zero.
    function automatic logic [OFS_W-1:0] vec_offset(input logic [CODE_W-1:0] c);
        logic [OFS_W-1:0] o;
        case (c)
            FC_RESET:           o = 16'h0001;
            FC_MCHK:            o = 16'h0401;
            FC_ARITH, FC_IOVF:  o = 16'h0501;
            FC_INTR:            o = 16'h0101;
            FC_NDTBM:           o = 16'h0201;
            FC_PDTBM:           o = 16'h0281;
            FC_ALIGN:           o = 16'h0301;
            FC_DFAULT, FC_DACV: o = 16'h0381;
            FC_ITBM, FC_IFAULT: o = 16'h0181;
            FC_IACV:            o = 16'h0081;
            FC_UNIMP:           o = 16'h0481;
            FC_FPDIS:           o = 16'h0581;
            FC_PCALL:           o = 16'h2001;
            default:            o = 16'h0000;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/trap_decode.sv
// trap_decode: purely combinational classification of the strobes.
// Decides whether a fault is accepted or rejected, whether a return is legal,
// how the saved address is updated and whether a bank switch is requested.
// Assumes fault_take has priority over ret_take.
module trap_decode
    import trap_pkg::*;
(
    input  logic              fault_take,
    input  logic [CODE_W-1:0] fault_code,
    input  logic              ret_take,
    input  logic              pc_priv,
    output logic              do_entry,
    output logic              do_arith,
    output logic              do_ret,
    output logic              do_ret_bad,
    output logic              want_shadow,
    output save_e             save_mode,
    output logic [OFS_W-1:0]  offset
);

    logic code_known;
    logic is_intr;
    logic is_pcall;

    // Recognise the code classes.
    always_comb begin
        code_known = (fault_code >= CODE_W'(FC_RESET)) && (fault_code <= CODE_W'(FC_IOVF))
                     && (fault_code != CODE_W'(FC_ARITH));
        is_intr    = (fault_code == CODE_W'(FC_INTR));
        is_pcall   = (fault_code == CODE_W'(FC_PCALL));
    end

    // Resolve strobes into actions, fault first.
    always_comb begin
        do_entry    = fault_take && code_known;
        do_arith    = fault_take && (fault_code == CODE_W'(FC_ARITH));
        do_ret      = ret_take && !fault_take && pc_priv;
        do_ret_bad  = ret_take && !fault_take && !pc_priv;
        want_shadow = do_entry && !pc_priv;
    end

    // Choose the restart-address policy.
    always_comb begin
        if (!do_entry)                save_mode = SAVE_KEEP;
        else if (is_intr && pc_priv)  save_mode = SAVE_KEEP;
        else if (is_pcall)            save_mode = SAVE_PC4;
        else                          save_mode = SAVE_PC;
    end

    // Look up the handler offset.
    always_comb offset = vec_offset(fault_code);

endmodule

// File: rtl/trap_ctx_regs.sv
// trap_ctx_regs: holds the vector base register and the saved restart
// address. The base loads on base_wr; the restart address follows the
// policy chosen by the decoder. Both use a synchronous active-low reset.
module trap_ctx_regs
    import trap_pkg::*;
#(
    parameter int           AW         = 64,
    parameter logic [AW-1:0] BASE_RESET = AW'(64'h0001_0000)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_wr,
    input  logic [AW-1:0] base_wdata,
    input  save_e         save_mode,
    input  logic [AW-1:0] cur_pc,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] exc_q
);

    localparam logic [AW-1:0] STEP = AW'(4);

    // Vector base register.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= BASE_RESET;
        else if (base_wr) base_q <= base_wdata;
    end

    // Saved restart address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_q <= '0;
        end else begin
            case (save_mode)
                SAVE_PC:  exc_q <= cur_pc;
                SAVE_PC4: exc_q <= cur_pc + STEP;
                default:  exc_q <= exc_q;
            endcase
        end
    end

endmodule

// File: rtl/trap_redirect.sv
// trap_redirect: registers the redirect target, its +4 companion and the
// one-cycle request pulses. Targets hold their value between redirects.
module trap_redirect #(
    parameter int            AW         = 64,
    parameter logic [AW-1:0] BASE_RESET = AW'(64'h0001_0000)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_entry,
    input  logic          do_ret,
    input  logic          do_ret_bad,
    input  logic          do_arith,
    input  logic          want_shadow,
    input  logic [AW-1:0] entry_target,
    input  logic [AW-1:0] exc_q,
    output logic [AW-1:0] next_pc,
    output logic [AW-1:0] next_npc,
    output logic          redirect,
    output logic          shadow_enter,
    output logic          shadow_exit,
    output logic          ret_illegal,
    output logic          arith_reject
);

    localparam logic [AW-1:0] STEP      = AW'(4);
    localparam logic [AW-1:0] RESET_VEC = BASE_RESET + AW'(1);

    logic [AW-1:0] tgt;

    // Pick the target of this cycle's redirect.
    always_comb tgt = do_entry ? entry_target : exc_q;

    // Target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc  <= RESET_VEC;
            next_npc <= RESET_VEC + STEP;
        end else if (do_entry || do_ret) begin
            next_pc  <= tgt;
            next_npc <= tgt + STEP;
        end
    end

    // One-cycle request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect     <= 1'b0;
            shadow_enter <= 1'b0;
            shadow_exit  <= 1'b0;
            ret_illegal  <= 1'b0;
            arith_reject <= 1'b0;
        end else begin
            redirect     <= do_entry || do_ret;
            shadow_enter <= want_shadow;
            shadow_exit  <= do_ret && !exc_q[0];
            ret_illegal  <= do_ret_bad;
            arith_reject <= do_arith;
        end
    end

endmodule

// File: rtl/trap_seq.sv
// trap_seq: top of the trap entry/return sequencer. Decodes the strobes,
// updates the base and restart-address registers, and registers the
// redirect. Assumes bit 0 of a PC marks privileged mode and that offsets
// fit in 16 bits (AW > 16).
module trap_seq
    import trap_pkg::*;
#(
    parameter int            AW         = 64,
    parameter logic [AW-1:0] BASE_RESET = AW'(64'h0001_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cur_pc,
    input  logic              fault_take,
    input  logic [CODE_W-1:0] fault_code,
    input  logic              ret_take,
    input  logic              base_wr,
    input  logic [AW-1:0]     base_wdata,
    output logic [AW-1:0]     next_pc,
    output logic [AW-1:0]     next_npc,
    output logic              redirect,
    output logic              shadow_enter,
    output logic              shadow_exit,
    output logic              ret_illegal,
    output logic              arith_reject,
    output logic [AW-1:0]     exc_addr
);

    logic             do_entry, do_arith, do_ret, do_ret_bad, want_shadow;
    save_e            save_mode;
    logic [OFS_W-1:0] offset;
    logic [AW-1:0]    base_q, exc_q, entry_target;

    trap_decode u_dec (
        .fault_take  (fault_take),
        .fault_code  (fault_code),
        .ret_take    (ret_take),
        .pc_priv     (cur_pc[0]),
        .do_entry    (do_entry),
        .do_arith    (do_arith),
        .do_ret      (do_ret),
        .do_ret_bad  (do_ret_bad),
        .want_shadow (want_shadow),
        .save_mode   (save_mode),
        .offset      (offset)
    );

    trap_ctx_regs #(.AW(AW), .BASE_RESET(BASE_RESET)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_wr    (base_wr),
        .base_wdata (base_wdata),
        .save_mode  (save_mode),
        .cur_pc     (cur_pc),
        .base_q     (base_q),
        .exc_q      (exc_q)
    );

    // Handler address from the current base.
    always_comb entry_target = base_q + AW'(offset);

    trap_redirect #(.AW(AW), .BASE_RESET(BASE_RESET)) u_red (
        .clk          (clk),
        .rst_n        (rst_n),
        .do_entry     (do_entry),
        .do_ret       (do_ret),
        .do_ret_bad   (do_ret_bad),
        .do_arith     (do_arith),
        .want_shadow  (want_shadow),
        .entry_target (entry_target),
        .exc_q        (exc_q),
        .next_pc      (next_pc),
        .next_npc     (next_npc),
        .redirect     (redirect),
        .shadow_enter (shadow_enter),
        .shadow_exit  (shadow_exit),
        .ret_illegal  (ret_illegal),
        .arith_reject (arith_reject)
    );

    // Restart address visible at the port.
    always_comb exc_addr = exc_q;

endmodule

// File: rtl/trap_seq_chk.sv
// trap_seq_chk: port-level temporal checks for trap_seq, bound to every
// instance of it.
module trap_seq_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] cur_pc,
    input logic          fault_take,
    input logic [4:0]    fault_code,
    input logic          ret_take,
    input logic [AW-1:0] next_pc,
    input logic [AW-1:0] next_npc,
    input logic          redirect,
    input logic          shadow_enter,
    input logic          shadow_exit,
    input logic          ret_illegal,
    input logic          arith_reject,
    input logic [AW-1:0] exc_addr
);

    a_r3_npc_step: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> next_npc == next_pc + AW'(4));

    a_r4_intr_keeps_exc: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_take && fault_code == 5'd4 && cur_pc[0]) |=> $stable(exc_addr));

    a_r5_enter_from_user: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_take && fault_code != 5'd3 && fault_code != 5'd0 && fault_code <= 5'd16 && !cur_pc[0])
        |=> (shadow_enter && redirect));

    a_r6_ret_target: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_take && !fault_take && cur_pc[0]) |=> (redirect && next_pc == $past(exc_addr)));

    a_r7_ret_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_take && !fault_take && !cur_pc[0]) |=> (ret_illegal && !redirect && $stable(next_pc)));

    a_r8_arith_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_take && fault_code == 5'd3) |=> (arith_reject && !redirect && $stable(exc_addr)));

    a_r9_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_take && ret_take) |=> (!shadow_exit && !ret_illegal));

    a_r2_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({redirect, ret_illegal, arith_reject}));

endmodule

bind trap_seq trap_seq_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cur_pc       (cur_pc),
    .fault_take   (fault_take),
    .fault_code   (fault_code),
    .ret_take     (ret_take),
    .next_pc      (next_pc),
    .next_npc     (next_npc),
    .redirect     (redirect),
    .shadow_enter (shadow_enter),
    .shadow_exit  (shadow_exit),
    .ret_illegal  (ret_illegal),
    .arith_reject (arith_reject),
    .exc_addr     (exc_addr)
);

// File: tb/sim_trap_seq.sv
// Bench for trap_seq: behavioural reference model compared every clock,
// plus directed checks of literal expected values.
module sim_trap_seq;

    localparam int          AW = 64;
    localparam logic [63:0] RB = 64'h0001_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cur_pc = '0;
    logic          fault_take = 1'b0;
    logic [4:0]    fault_code = '0;
    logic          ret_take = 1'b0;
    logic          base_wr = 1'b0;
    logic [AW-1:0] base_wdata = '0;
    logic [AW-1:0] next_pc, next_npc, exc_addr;
    logic          redirect, shadow_enter, shadow_exit, ret_illegal, arith_reject;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_on   = 1'b0;

    always #10 clk = ~clk;

    trap_seq #(.AW(AW), .BASE_RESET(RB)) u0 (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .fault_take(fault_take),
        .fault_code(fault_code), .ret_take(ret_take), .base_wr(base_wr),
        .base_wdata(base_wdata), .next_pc(next_pc), .next_npc(next_npc),
        .redirect(redirect), .shadow_enter(shadow_enter), .shadow_exit(shadow_exit),
        .ret_illegal(ret_illegal), .arith_reject(arith_reject), .exc_addr(exc_addr)
    );

    // Offsets per code, from R2.
    function automatic logic [63:0] ofs(input int c);
        case (c)
            1: return 64'h0001;   2: return 64'h0401;   4: return 64'h0101;
            5: return 64'h0201;   6: return 64'h0281;   7: return 64'h0301;
            8: return 64'h0381;   9: return 64'h0381;  10: return 64'h0181;
            11: return 64'h0181; 12: return 64'h0081;  13: return 64'h0481;
            14: return 64'h0581; 15: return 64'h2001;  16: return 64'h0501;
            default: return 64'h0;
        endcase
    endfunction

    // Reference model state.
    logic [63:0] m_base, m_exc, m_pc, m_npc;
    bit m_red, m_se, m_sx, m_ri, m_ar;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = RB; m_exc = 0; m_pc = RB + 1; m_npc = RB + 5;
            m_red = 0; m_se = 0; m_sx = 0; m_ri = 0; m_ar = 0;
        end else begin
            m_red = 0; m_se = 0; m_sx = 0; m_ri = 0; m_ar = 0;
            if (fault_take) begin
                if (fault_code == 5'd3) m_ar = 1;
                else if (fault_code >= 5'd1 && fault_code <= 5'd16) begin
                    if (!(fault_code == 5'd4 && cur_pc[0]))
                        m_exc = (fault_code == 5'd15) ? cur_pc + 4 : cur_pc;
                    m_pc = m_base + ofs(int'(fault_code));
                    m_npc = m_pc + 4;
                    m_red = 1;
                    m_se = !cur_pc[0];
                end
            end else if (ret_take) begin
                if (!cur_pc[0]) m_ri = 1;
                else begin
                    m_pc = m_exc; m_npc = m_exc + 4; m_red = 1; m_sx = !m_exc[0];
                end
            end
            if (base_wr) m_base = base_wdata;
        end
    end

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Model comparison on every clock, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2 next_pc", next_pc, m_pc);
            chk("R3 next_npc", next_npc, m_npc);
            chk("R4 exc_addr", exc_addr, m_exc);
            chk("R2 redirect", 64'(redirect), 64'(m_red));
            chk("R5 shadow_enter", 64'(shadow_enter), 64'(m_se));
            chk("R6 shadow_exit", 64'(shadow_exit), 64'(m_sx));
            chk("R7 ret_illegal", 64'(ret_illegal), 64'(m_ri));
            chk("R8 arith_reject", 64'(arith_reject), 64'(m_ar));
        end
    end

    // Drive one stimulus cycle, then idle; outputs are then readable.
    task automatic apply(input bit ft, input int code, input bit rt,
                         input logic [63:0] pc, input bit bw, input logic [63:0] bd);
        @(negedge clk);
        fault_take = ft; fault_code = 5'(code); ret_take = rt; cur_pc = pc;
        base_wr = bw; base_wdata = bd;
        @(negedge clk);
        fault_take = 0; ret_take = 0; base_wr = 0;
    endtask

    logic [63:0] saved;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        // R1 reset state
        chk("R1 reset pc", next_pc, RB + 1);
        chk("R1 reset npc", next_npc, RB + 5);
        chk("R1 reset exc", exc_addr, 0);
        chk("R1 reset pulses", 64'({redirect, shadow_enter, shadow_exit, ret_illegal, arith_reject}), 0);

        // R2 R5: native data-TLB miss from ordinary mode
        apply(1, 5, 0, 64'h1000, 0, 0);
        chk("R2 dtb miss vector", next_pc, RB + 64'h201);
        chk("R5 enter shadow", 64'(shadow_enter), 1);
        chk("R4 saved pc", exc_addr, 64'h1000);

        // R6: return from privileged mode
        apply(0, 0, 1, RB + 64'h201, 0, 0);
        chk("R6 return target", next_pc, 64'h1000);
        chk("R6 shadow exit", 64'(shadow_exit), 1);

        // R4: privileged call skips instruction
        apply(1, 15, 0, 64'h2000, 0, 0);
        chk("R4 pcall saved +4", exc_addr, 64'h2004);
        chk("R2 pcall vector", next_pc, RB + 64'h2001);

        // R4 R5: interrupt inside privileged mode keeps saved address
        apply(1, 4, 0, RB + 64'h2011, 0, 0);
        chk("R4 intr priv keeps exc", exc_addr, 64'h2004);
        chk("R5 no enter from priv", 64'(shadow_enter), 0);
        apply(0, 0, 1, RB + 64'h105, 0, 0);
        chk("R6 return after nested intr", next_pc, 64'h2004);

        // R4: interrupt from ordinary mode saves PC
        apply(1, 4, 0, 64'h3000, 0, 0);
        chk("R4 intr user saves pc", exc_addr, 64'h3000);

        // R7: return outside privileged mode
        saved = next_pc;
        apply(0, 0, 1, 64'h3000, 0, 0);
        chk("R7 illegal flag", 64'(ret_illegal), 1);
        chk("R7 no redirect", 64'(redirect), 0);
        chk("R7 pc kept", next_pc, saved);

        // R8: arithmetic rejected
        apply(1, 3, 0, 64'h4000, 0, 0);
        chk("R8 arith flag", 64'(arith_reject), 1);
        chk("R8 exc kept", exc_addr, 64'h3000);

        // R9: simultaneous strobes
        apply(1, 2, 1, 64'h5001, 0, 0);
        chk("R9 fault wins", next_pc, RB + 64'h401);
        chk("R9 no ret pulse", 64'({shadow_exit, ret_illegal}), 0);
        // saved address now has bit 0 set: return keeps shadow bank (R6)
        apply(0, 0, 1, RB + 64'h401, 0, 0);
        chk("R6 no exit when saved bit0", 64'(shadow_exit), 0);
        chk("R6 target priv", next_pc, 64'h5001);

        // R10: unknown codes ignored
        saved = next_pc;
        apply(1, 0, 0, 64'h6000, 0, 0);
        chk("R10 code0 ignored", next_pc, saved);
        apply(1, 17, 0, 64'h6000, 0, 0);
        chk("R10 code17 ignored", exc_addr, 64'h5001);
        chk("R10 no pulse", 64'({redirect, shadow_enter, arith_reject}), 0);

        // R11: base write same cycle as fault uses old base
        apply(1, 16, 0, 64'h7000, 1, 64'h0008_0000);
        chk("R11 old base used", next_pc, RB + 64'h501);
        apply(1, 7, 0, 64'h7000, 0, 0);
        chk("R11 new base used", next_pc, 64'h0008_0301);

        // R2: every accepted code from ordinary mode
        for (int c = 1; c <= 16; c++) begin
            if (c != 3) begin
                apply(1, c, 0, 64'h8000, 0, 0);
                chk("R2 sweep vector", next_pc, 64'h0008_0000 + ofs(c));
            end
        end

        // Random mixes checked by the model.
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            fault_take = ($urandom_range(0, 3) == 0);
            fault_code = 5'($urandom_range(0, 20));
            ret_take   = ($urandom_range(0, 2) == 0);
            cur_pc     = {32'h0, $urandom} & ~64'h2;
            base_wr    = ($urandom_range(0, 15) == 0);
            base_wdata = {32'h0, $urandom & 32'hffff_c000};
        end
        @(negedge clk);
        fault_take = 0; ret_take = 0; base_wr = 0;
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule